// File: doc/BRIEF.md
# SPI Master Chip-Select Sequencer

This block owns the four active-low peripheral select lines of an SPI master. A transfer request names a target through a 4-bit select code. The code comes either from a configuration field or from the request itself. In normal mode the code is decoded by its lowest zero bit into a single active line. In raw mode the code is driven onto the lines unchanged. When the target differs from the select currently asserted, the block first releases every line. It holds them released for a programmable number of clocks, then drives the new target, so that two peripherals are never selected at once.

Requests arrive on a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A source that raises `req_valid` while ready is low must hold it, and must hold the select code stable, until it sees ready high at a clock edge. The request is accepted at that edge. The target and the mode bits are captured at acceptance, so later changes do not affect a sequence in progress. A one-clock `req_done` pulse reports that the target select is in place. A separate end-of-transfer strobe latches the line state for status readback.

Top module: `spi_cs_sequencer`

## Requirements
- R1: After reset `cs_n` is 4'b1111, `req_ready` is 1, `req_done` is 0, `stat_cs` is 0 and `err_forbidden` is 0.
- R2: In normal mode (`cfg_raw_mode`=0) the target is chosen by the lowest zero bit of the code. Bit0=0 gives `cs_n`=1110. Bits[1:0]=01 gives 1101. Bits[2:0]=011 gives 1011. Code 0111 gives 0111. A low `cs_n[i]` selects peripheral i.
- R3: In normal mode code 1111 is forbidden. The request is dropped with no `req_done`, `cs_n` is unchanged, and `err_forbidden` goes to 1 and stays 1 until reset.
- R4: In raw mode (`cfg_raw_mode`=1) the target is the code itself, bit for bit, and 1111 is accepted as a release of all lines.
- R5: With `cfg_var_sel`=0 the code is taken from `cfg_sel` and `req_sel` has no effect. With `cfg_var_sel`=1 the code is taken from `req_sel`.
- R6: When the target differs from a `cs_n` value that has at least one low line, `cs_n` reads 1111 for exactly max(`cfg_gap`,1) clocks before the target appears. When `cs_n` is 1111, a new target appears on the clock after acceptance.
- R7: A request whose target equals the current `cs_n` leaves `cs_n` unchanged with no released cycles. `req_done` follows on the clock after acceptance.
- R8: `req_done` is a one-clock pulse. It is high in the first clock in which the new `cs_n` value is visible.
- R9: `req_ready` is low from acceptance through the `req_done` cycle. The target is latched at acceptance, and input changes during a sequence do not alter it.
- R10: On an `xfer_end` strobe, `cs_n` is captured when `cfg_master`=1 and zero is captured otherwise. `stat_cs` reads zero whenever `cfg_master`=0.
- R11: `cs_n` never changes directly from one value with a low line to a different value with a low line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_raw_mode | input | 1 | 1: drive code onto lines unchanged; 0: lowest-zero decode |
| cfg_var_sel | input | 1 | 1: code from `req_sel`; 0: code from `cfg_sel` |
| cfg_sel | input | 4 | Configured select code |
| cfg_gap | input | 8 | Release gap length in clocks (0 acts as 1) |
| cfg_master | input | 1 | Master mode enable for status capture |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_sel | input | 4 | Per-request select code |
| req_done | output | 1 | One-clock pulse: target select in place |
| xfer_end | input | 1 | End-of-transfer strobe |
| cs_n | output | 4 | Active-low peripheral selects |
| stat_cs | output | 4 | Select state captured at last transfer end |
| err_forbidden | output | 1 | Sticky flag: forbidden code requested |

## Verification
On every cycle the assertions check several rules. Selects never move directly between two active values. The error flag never clears. `req_done` never lasts two cycles, and a dropped request leaves the lines alone. The release gap matches the length loaded, the decoder yields exactly one active line for a legal code, and the status is zero outside master mode. Only the bench scenarios can show the mapping from each code to its lines, the source choice between `cfg_sel` and `req_sel`, and the exact gap count against a programmed value. They also cover the same-target shortcut, the raw release, and the latching of the target against inputs that change mid-sequence.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_GAP  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/spi_cs_decode.sv
module spi_cs_decode #(
  parameter int NCS = 4
) (
  input  logic [NCS-1:0] sel,
  output logic [NCS-1:0] cs_n,
  output logic           forbidden
);
  logic [NCS:0]   ones_below;
  logic [NCS-1:0] hot;

  assign ones_below[0] = 1'b1;

  // Prefix chain: line i wins when bit i is zero and every lower bit is one.
  for (genvar i = 0; i < NCS; i++) begin : g_chain
    assign ones_below[i+1] = ones_below[i] & sel[i];
    assign hot[i]          = ones_below[i] & ~sel[i];
  end

  assign forbidden = ones_below[NCS];
  assign cs_n      = ~hot;

  always_comb begin
    if (!forbidden) begin
      assert_decode_onehot_R2: assert ($countones(cs_n) == NCS - 1)
        else $error("decode produced more or fewer than one active line");
    end
  end
endmodule

// File: rtl/spi_cs_gap_timer.sv
module spi_cs_gap_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [GAP_W-1:0] load_val,
  output logic             busy,
  output logic             expire
);
  logic [GAP_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= (load_val == '0) ? '0 : load_val - 1'b1;
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign expire = busy && (cnt == '0);

  // Checker: count the cycles spent busy and compare with the length loaded.
  logic [GAP_W-1:0] chk_load;
  logic [GAP_W-1:0] chk_elapsed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_load    <= '0;
      chk_elapsed <= '0;
    end else if (start) begin
      chk_load    <= load_val;
      chk_elapsed <= '0;
    end else if (busy) begin
      chk_elapsed <= chk_elapsed + 1'b1;
    end
  end

  assert_gap_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (chk_elapsed == ((chk_load == '0) ? '0 : chk_load - 1'b1)))
    else $error("release gap length differs from programmed value");
endmodule

// File: rtl/spi_cs_status.sv
module spi_cs_status #(
  parameter int NCS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           xfer_end,
  input  logic           master,
  input  logic [NCS-1:0] cs_n,
  output logic [NCS-1:0] stat
);
  logic [NCS-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        snap_q <= '0;
    else if (xfer_end) snap_q <= master ? cs_n : '0;
  end

  assign stat = master ? snap_q : '0;

  assert_stat_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat != '0) |-> master)
    else $error("status nonzero outside master mode");
endmodule

// File: rtl/spi_cs_sequencer.sv
module spi_cs_sequencer
  import spi_cs_pkg::*;
#(
  parameter int NCS   = 4,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_raw_mode,
  input  logic             cfg_var_sel,
  input  logic [NCS-1:0]   cfg_sel,
  input  logic [GAP_W-1:0] cfg_gap,
  input  logic             cfg_master,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [NCS-1:0]   req_sel,
  output logic             req_done,
  input  logic             xfer_end,
  output logic [NCS-1:0]   cs_n,
  output logic [NCS-1:0]   stat_cs,
  output logic             err_forbidden
);
  localparam logic [NCS-1:0] ALL_OFF = '1;

  seq_state_e     state_q;
  logic [NCS-1:0] cs_q;
  logic [NCS-1:0] tgt_q;
  logic           err_q;

  logic [NCS-1:0] code;
  logic [NCS-1:0] dec_n;
  logic [NCS-1:0] tgt_d;
  logic           forbid;
  logic           drop;
  logic           accept;
  logic           same;
  logic           released;
  logic           gap_start;
  logic           gap_busy;
  logic           gap_expire;

  assign code = cfg_var_sel ? req_sel : cfg_sel;

  spi_cs_decode #(.NCS(NCS)) u_decode (
    .sel       (code),
    .cs_n      (dec_n),
    .forbidden (forbid)
  );

  assign tgt_d     = cfg_raw_mode ? code : dec_n;
  assign drop      = !cfg_raw_mode && forbid;
  assign req_ready = (state_q == SEQ_IDLE);
  assign accept    = req_valid && req_ready;
  assign same      = (tgt_d == cs_q);
  assign released  = (cs_q == ALL_OFF);
  assign gap_start = accept && !drop && !same && !released;

  spi_cs_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (gap_start),
    .load_val (cfg_gap),
    .busy     (gap_busy),
    .expire   (gap_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cs_q    <= ALL_OFF;
      tgt_q   <= ALL_OFF;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (accept) begin
            if (drop) begin
              err_q <= 1'b1;
            end else if (same) begin
              state_q <= SEQ_DONE;
            end else if (released) begin
              cs_q    <= tgt_d;
              state_q <= SEQ_DONE;
            end else begin
              cs_q    <= ALL_OFF;
              tgt_q   <= tgt_d;
              state_q <= SEQ_GAP;
            end
          end
        end
        SEQ_GAP: begin
          if (gap_expire) begin
            cs_q    <= tgt_q;
            state_q <= SEQ_DONE;
          end
        end
        SEQ_DONE: state_q <= SEQ_IDLE;
        default:  state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign cs_n          = cs_q;
  assign req_done      = (state_q == SEQ_DONE);
  assign err_forbidden = err_q;

  spi_cs_status #(.NCS(NCS)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .xfer_end (xfer_end),
    .master   (cfg_master),
    .cs_n     (cs_q),
    .stat     (stat_cs)
  );

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_q) != ALL_OFF && cs_q != ALL_OFF) |-> (cs_q == $past(cs_q)))
    else $error("selects moved between two active values");

  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q)
    else $error("forbidden flag cleared");

  assert_drop_no_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && drop) |=> (cs_q == $past(cs_q) && !req_done))
    else $error("dropped request changed selects");

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done)
    else $error("done longer than one cycle");

  assert_gap_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gap_busy |-> (cs_q == ALL_OFF))
    else $error("a select active during release gap");
endmodule

// File: tb/spi_cs_sequencer_bench.sv
module spi_cs_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_raw_mode = 1'b0;
  logic       cfg_var_sel = 1'b0;
  logic [3:0] cfg_sel = 4'hF;
  logic [7:0] cfg_gap = 8'd0;
  logic       cfg_master = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [3:0] req_sel = 4'hF;
  logic       req_done;
  logic       xfer_end = 1'b0;
  logic [3:0] cs_n;
  logic [3:0] stat_cs;
  logic       err_forbidden;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [3:0] exp_cs = 4'hF;
  bit exp_err = 1'b0;

  always #10 clk = ~clk;

  spi_cs_sequencer u_spi_cs_sequencer (
    .clk(clk), .rst_n(rst_n), .cfg_raw_mode(cfg_raw_mode), .cfg_var_sel(cfg_var_sel),
    .cfg_sel(cfg_sel), .cfg_gap(cfg_gap), .cfg_master(cfg_master),
    .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel), .req_done(req_done),
    .xfer_end(xfer_end), .cs_n(cs_n), .stat_cs(stat_cs), .err_forbidden(err_forbidden)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] lowest_zero(input logic [3:0] s);
    if (!s[0])      return 4'b1110;
    else if (!s[1]) return 4'b1101;
    else if (!s[2]) return 4'b1011;
    else if (!s[3]) return 4'b0111;
    else            return 4'b1111;
  endfunction

  // One request; called and returns at a falling edge with the sequencer idle.
  task automatic txn(input bit raw, input bit vsel, input logic [3:0] csel,
                     input logic [3:0] rsel, input logic [7:0] gap);
    logic [3:0] code;
    logic [3:0] tgt;
    int n_exp;
    int hi;
    bit ready_ok;
    bit dark_ok;
    code = vsel ? rsel : csel;
    tgt  = raw ? code : lowest_zero(code);
    cfg_raw_mode = raw; cfg_var_sel = vsel; cfg_sel = csel; req_sel = rsel; cfg_gap = gap;
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R9 ready when idle", int'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    // scramble inputs after acceptance: target must stay latched (R9, R5)
    req_sel = ~rsel; cfg_sel = ~csel; cfg_raw_mode = ~raw; cfg_gap = 8'd3;
    if (!raw && code == 4'hF) begin
      exp_err = 1'b1;
      chk(err_forbidden == 1'b1, "R3 err set", int'(err_forbidden), 1);
      chk(cs_n == exp_cs, "R3 cs unchanged", int'(cs_n), int'(exp_cs));
      chk(req_done == 1'b0, "R3 no done", int'(req_done), 0);
      @(negedge clk);
      chk(req_done == 1'b0 && req_ready == 1'b1, "R3 dropped", int'(req_done), 0);
      return;
    end
    if (tgt == exp_cs) begin
      chk(req_done == 1'b1 && cs_n == tgt, "R7 same target", int'(cs_n), int'(tgt));
    end else begin
      n_exp = (exp_cs == 4'hF) ? 0 : ((gap == 8'd0) ? 1 : int'(gap));
      hi = 0; ready_ok = 1'b1; dark_ok = 1'b1;
      for (int g = 0; g < 600 && !req_done; g++) begin
        if (cs_n != 4'hF) dark_ok = 1'b0;
        if (req_ready) ready_ok = 1'b0;
        hi++;
        @(negedge clk);
      end
      chk(hi == n_exp, "R6 gap length", hi, n_exp);
      chk(dark_ok, "R11 released during gap", 0, 1);
      chk(ready_ok && !req_ready, "R9 ready low while busy", int'(req_ready), 0);
      chk(cs_n == tgt, raw ? "R4 raw target" : "R2 decoded target", int'(cs_n), int'(tgt));
      chk(req_done == 1'b1, "R8 done with new select", int'(req_done), 1);
    end
    exp_cs = tgt;
    @(negedge clk);
    chk(req_done == 1'b0, "R8 done one cycle", int'(req_done), 0);
    chk(req_ready == 1'b1 && cs_n == exp_cs, "R9 back to idle", int'(cs_n), int'(exp_cs));
  endtask

  task automatic status_probe();
    cfg_master = 1'b1; xfer_end = 1'b1;
    @(negedge clk);
    xfer_end = 1'b0;
    chk(stat_cs == exp_cs, "R10 capture in master", int'(stat_cs), int'(exp_cs));
    cfg_master = 1'b0;
    #1;
    chk(stat_cs == 4'h0, "R10 zero outside master", int'(stat_cs), 0);
    xfer_end = 1'b1;
    @(negedge clk);
    xfer_end = 1'b0; cfg_master = 1'b1;
    #1;
    chk(stat_cs == 4'h0, "R10 non-master capture is zero", int'(stat_cs), 0);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20250611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 4'hF && stat_cs == 4'h0 && !err_forbidden, "R1 reset outputs", int'(cs_n), 15);
    chk(req_ready == 1'b1 && req_done == 1'b0, "R1 reset handshake", int'(req_ready), 1);

    // R2 each decode pattern, from released lines then with gaps
    txn(1'b0, 1'b0, 4'b1010, 4'hF, 8'd2);
    txn(1'b0, 1'b0, 4'b0101, 4'hF, 8'd0);
    txn(1'b0, 1'b0, 4'b1011, 4'hF, 8'd4);
    txn(1'b0, 1'b0, 4'b0111, 4'hF, 8'd1);
    // R7 same target
    txn(1'b0, 1'b0, 4'b1111 ^ 4'b1000, 4'h0, 8'd5);
    // R3 forbidden, R5 req_sel ignored when cfg_var_sel=0
    txn(1'b0, 1'b0, 4'hF, 4'h0, 8'd2);
    // R5 code from req_sel
    txn(1'b0, 1'b1, 4'hF, 4'b1100, 8'd3);
    // R4 raw multi-line and raw release
    txn(1'b1, 1'b0, 4'b0101, 4'h0, 8'd2);
    txn(1'b1, 1'b1, 4'h0, 4'hF, 8'd0);
    txn(1'b1, 1'b0, 4'b1001, 4'h0, 8'd1);
    status_probe();
    // R6 long gap
    txn(1'b0, 1'b0, 4'b1110, 4'h0, 8'd200);
    status_probe();

    for (int k = 0; k < 80; k++) begin
      txn(($urandom % 4) == 0, 1'($urandom), 4'($urandom), 4'($urandom), 8'($urandom % 6));
      if ((k % 10) == 0) status_probe();
    end

    chk(err_forbidden == exp_err, "R3 err sticky", int'(err_forbidden), int'(exp_err));
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule